// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Sequencer

This block is a bus master that performs one indivisible read-then-write operation on an asynchronous external bus. The bus is 16 bits wide by default. A single request carries four things: an address, a function code, an operand size and a modify operation. The sequencer then reads the operand and computes the new value from the read data and the request's write data. It writes the result back while holding the bus locked. When no write is needed, the write half is left out.

The state register runs on a clock at twice the bus rate. Each clock cycle is one half-bus-clock phase. All bus outputs come from registers. The strobes and the locked-cycle indicator are active low.

The slave ends each half through a two-bit size acknowledge. If either bit is low, the half ends. The sequencer passes the acknowledge through a synchronizer and adds wait states until it recognizes the acknowledge. It reports the number of wait states as a debug count.

Top module: `rmw_seq`

## Requirements
- R1: In the first phase after a request is accepted, `lock_n` goes low and `bus_rw` is 1 (read). In that same phase `bus_addr`, `bus_fc` and `bus_siz` show the request's values, and both strobes are still high.
- R2: In the read half, `as_n` and `ds_n` fall together, exactly one phase after `lock_n` falls.
- R3: Each acknowledge bit is low-active, and either bit on its own is enough. An acknowledge becomes visible only after two register stages. It is tested at the end of the third phase of a half, and after that at the end of every second phase. Each failed test adds one bus-clock wait state (two phases) and increments `wait_cnt`. `wait_cnt` is cleared when a request is accepted and totals both halves. Suppose the slave pulls an acknowledge bit low at the falling clock edge of strobe phase D+1, where strobe phase 1 is the first phase with `as_n` low. The half then takes (D+2)/2 wait states, using integer division.
- R4: `din` is captured at the end of the phase before the strobes rise in the read half. The captured value is presented on `rdata` when `done` pulses.
- R5: `bus_rw` goes low only in the first phase of the write half, and `as_n` falls in the phase after it. `dben` first rises two phases after `bus_rw` falls. `dben` is never high while `bus_rw` is 1.
- R6: In the write half, `ds_n` falls two phases after `as_n`.
- R7: `req_op` selects the write value from the read data m and the write data w. The encodings are: 2'b00 means no write, 2'b01 writes w, 2'b10 writes m|w, and 2'b11 writes m^w. The value is on `dout` in the phase where `ds_n` falls in the write half.
- R8: Between the read half and the write half, both strobes stay high for exactly GAP_PH+1 phases: the release phase plus GAP_PH idle phases. `bus_addr` does not change while `lock_n` is low.
- R9: `lock_n` stays low from the first phase until the operation finishes. It rises in the same phase as a single-phase `done` pulse.
- R10: With op 2'b00, `bus_rw` never goes low and `dben` never rises. `done` pulses in the phase right after the read-half release phase.
- R11: During reset, `as_n`, `ds_n` and `lock_n` are high, `bus_rw` is 1, and `dben` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, twice the bus rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Start pulse, taken when idle |
| req_addr | input | AW | Operand address |
| req_fc | input | FCW | Address-space function code |
| req_siz | input | 2 | Operand size code |
| req_op | input | 2 | Modify operation |
| req_wdata | input | DW | Write data operand |
| sack_n | input | 2 | Size acknowledge from slave, active low |
| din | input | DW | Read data from the bus |
| bus_addr | output | AW | Bus address |
| bus_fc | output | FCW | Bus function code |
| bus_siz | output | 2 | Bus size code |
| bus_rw | output | 1 | 1 = read, 0 = write |
| as_n | output | 1 | Address strobe |
| ds_n | output | 1 | Data strobe |
| lock_n | output | 1 | Locked-cycle indicator |
| dben | output | 1 | Write data drive enable |
| dout | output | DW | Write data to the bus |
| rdata | output | DW | Captured read data |
| done | output | 1 | Completion pulse |
| wait_cnt | output | WCW | Wait states inserted in the last operation |

## Verification
Two events can land in the same clock cycle. The synchronized acknowledge can reach its test point in exactly the phase that decides between a wait state and moving on. Also, `done` rises in the same phase that `lock_n` is released. The bench models a slave whose acknowledge delay can be set separately for each half. It sweeps that delay across odd and even values, so that recognition falls both just before and just after a test point. Each run is judged by comparing `wait_cnt` with the integer formula and by checking, phase by phase, that `lock_n` rises exactly where `done` pulses.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_R0, ST_R1, ST_R2, ST_RWA, ST_RWB, ST_R3, ST_R4, ST_R5,
    ST_GAP, ST_W0, ST_W1, ST_W2, ST_WWA, ST_WWB, ST_W3, ST_W4, ST_W5
  } rmw_st_e;

  typedef enum logic [1:0] {
    OP_SKIP  = 2'b00,
    OP_STORE = 2'b01,
    OP_SET   = 2'b10,
    OP_FLIP  = 2'b11
  } rmw_op_e;

  typedef struct packed {
    logic as_n;
    logic ds_n;
    logic rw;
    logic lock_n;
    logic dben;
  } rmw_bus_t;

  // Bus control levels for the phase a state represents.
  function automatic rmw_bus_t phase_levels(rmw_st_e s);
    rmw_bus_t b;
    b = '{as_n: 1'b1, ds_n: 1'b1, rw: 1'b1, lock_n: 1'b1, dben: 1'b0};
    case (s)
      ST_R0, ST_R5, ST_GAP: b.lock_n = 1'b0;
      ST_R1, ST_R2, ST_RWA, ST_RWB, ST_R3, ST_R4: begin
        b.lock_n = 1'b0; b.as_n = 1'b0; b.ds_n = 1'b0;
      end
      ST_W0: begin b.lock_n = 1'b0; b.rw = 1'b0; end
      ST_W1: begin b.lock_n = 1'b0; b.rw = 1'b0; b.as_n = 1'b0; end
      ST_W2: begin
        b.lock_n = 1'b0; b.rw = 1'b0; b.as_n = 1'b0; b.dben = 1'b1;
      end
      ST_WWA, ST_WWB, ST_W3, ST_W4: begin
        b.lock_n = 1'b0; b.rw = 1'b0; b.as_n = 1'b0; b.ds_n = 1'b0;
        b.dben = 1'b1;
      end
      ST_W5: begin b.lock_n = 1'b0; b.rw = 1'b0; b.dben = 1'b1; end
      default: ;
    endcase
    return b;
  endfunction

  function automatic logic drives_data(rmw_st_e s);
    return (s == ST_W2) || (s == ST_WWA) || (s == ST_WWB) ||
           (s == ST_W3) || (s == ST_W4) || (s == ST_W5);
  endfunction

endpackage

// File: rtl/rmw_ack_sync.sv
module rmw_ack_sync #(
  parameter int AW_BITS = 2,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW_BITS-1:0] ack_n,
  output logic               ack_seen
);
  logic [AW_BITS-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= ~ack_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
      end
    end
  endgenerate

  assign ack_seen = |stage_q[STAGES-1];
endmodule

// File: rtl/rmw_phase_fsm.sv
module rmw_phase_fsm
  import rmw_pkg::*;
#(
  parameter int GAP_PH = 2,
  parameter int WCW    = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           skip_wr,
  input  logic           ack_seen,
  output rmw_st_e        st,
  output rmw_st_e        nxt,
  output logic [WCW-1:0] wait_cnt
);
  localparam int GCW = $clog2(GAP_PH + 1);

  logic [GCW-1:0] gap_q;
  logic           gap_last;
  logic           wait_enter;

  assign gap_last   = (gap_q == GCW'(GAP_PH - 1));
  assign wait_enter = (nxt == ST_RWA || nxt == ST_WWA) &&
                      !(st == ST_RWA || st == ST_WWA);

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE: if (start) nxt = ST_R0;
      ST_R0:   nxt = ST_R1;
      ST_R1:   nxt = ST_R2;
      ST_R2, ST_RWB: nxt = ack_seen ? ST_R3 : ST_RWA;
      ST_RWA:  nxt = ST_RWB;
      ST_R3:   nxt = ST_R4;
      ST_R4:   nxt = ST_R5;
      ST_R5:   nxt = skip_wr ? ST_IDLE : ST_GAP;
      ST_GAP:  if (gap_last) nxt = ST_W0;
      ST_W0:   nxt = ST_W1;
      ST_W1:   nxt = ST_W2;
      ST_W2, ST_WWB: nxt = ack_seen ? ST_W3 : ST_WWA;
      ST_WWA:  nxt = ST_WWB;
      ST_W3:   nxt = ST_W4;
      ST_W4:   nxt = ST_W5;
      ST_W5:   nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      gap_q    <= '0;
      wait_cnt <= '0;
    end else begin
      st    <= nxt;
      gap_q <= (st == ST_GAP) ? gap_q + 1'b1 : '0;
      if (st == ST_IDLE && start)             wait_cnt <= '0;
      else if (wait_enter && wait_cnt != '1)  wait_cnt <= wait_cnt + 1'b1;
    end
  end

  // A failed test in a sample phase must lead into a wait state.
  AST_NOACK_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_R2 || st == ST_W2) && !ack_seen) |=> (st == ST_RWA || st == ST_WWA)); // R3
endmodule

// File: rtl/rmw_bus_drive.sv
module rmw_bus_drive
  import rmw_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rmw_st_e       st,
  input  rmw_st_e       nxt,
  input  logic [DW-1:0] wr_val,
  output logic          as_n,
  output logic          ds_n,
  output logic          rw,
  output logic          lock_n,
  output logic          dben,
  output logic [DW-1:0] dout,
  output logic          done
);
  rmw_bus_t lv;
  logic     finish_ev;

  assign lv        = phase_levels(nxt);
  assign finish_ev = (nxt == ST_IDLE) && (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_n <= 1'b1; ds_n <= 1'b1; rw <= 1'b1; lock_n <= 1'b1;
      dben <= 1'b0; dout <= '0;   done <= 1'b0;
    end else begin
      as_n   <= lv.as_n;
      ds_n   <= lv.ds_n;
      rw     <= lv.rw;
      lock_n <= lv.lock_n;
      dben   <= lv.dben;
      dout   <= drives_data(nxt) ? wr_val : '0;
      done   <= finish_ev;
    end
  end

  AST_DBEN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dben |-> !rw); // R5
  AST_DONE_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 16,
  parameter int FCW    = 4,
  parameter int GAP_PH = 2,
  parameter int WCW    = 8,
  parameter int SYNC   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic [AW-1:0]  req_addr,
  input  logic [FCW-1:0] req_fc,
  input  logic [1:0]     req_siz,
  input  logic [1:0]     req_op,
  input  logic [DW-1:0]  req_wdata,
  input  logic [1:0]     sack_n,
  input  logic [DW-1:0]  din,
  output logic [AW-1:0]  bus_addr,
  output logic [FCW-1:0] bus_fc,
  output logic [1:0]     bus_siz,
  output logic           bus_rw,
  output logic           as_n,
  output logic           ds_n,
  output logic           lock_n,
  output logic           dben,
  output logic [DW-1:0]  dout,
  output logic [DW-1:0]  rdata,
  output logic           done,
  output logic [WCW-1:0] wait_cnt
);
  rmw_st_e       st, nxt;
  rmw_op_e       op_q;
  logic [DW-1:0] wdata_q, wr_val;
  logic          ack_seen;
  logic          accept_ev, capture_ev, modify_ev;

  function automatic logic [DW-1:0] modify(rmw_op_e op, logic [DW-1:0] m,
                                           logic [DW-1:0] w);
    case (op)
      OP_STORE: return w;
      OP_SET:   return m | w;
      OP_FLIP:  return m ^ w;
      default:  return m;
    endcase
  endfunction

  assign accept_ev  = (st == ST_IDLE) && req;
  assign capture_ev = (st == ST_R4);
  assign modify_ev  = (st == ST_GAP);

  rmw_ack_sync #(.AW_BITS(2), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .ack_n(sack_n), .ack_seen(ack_seen));

  rmw_phase_fsm #(.GAP_PH(GAP_PH), .WCW(WCW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(req), .skip_wr(op_q == OP_SKIP),
    .ack_seen(ack_seen), .st(st), .nxt(nxt), .wait_cnt(wait_cnt));

  rmw_bus_drive #(.DW(DW)) u_drv (
    .clk(clk), .rst_n(rst_n), .st(st), .nxt(nxt), .wr_val(wr_val),
    .as_n(as_n), .ds_n(ds_n), .rw(bus_rw), .lock_n(lock_n), .dben(dben),
    .dout(dout), .done(done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr <= '0; bus_fc <= '0; bus_siz <= '0; op_q <= OP_SKIP;
      wdata_q  <= '0; rdata  <= '0; wr_val  <= '0;
    end else begin
      if (accept_ev) begin
        bus_addr <= req_addr;
        bus_fc   <= req_fc;
        bus_siz  <= req_siz;
        op_q     <= rmw_op_e'(req_op);
        wdata_q  <= req_wdata;
      end
      if (capture_ev) rdata  <= din;
      if (modify_ev)  wr_val <= modify(op_q, rdata, wdata_q);
    end
  end

  AST_READ_STROBES_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(as_n) && bus_rw) |-> !ds_n); // R2
  AST_WRITE_DS_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(as_n) && !bus_rw) |-> ds_n); // R6
  AST_STROBE_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> !lock_n); // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_n && $past(!lock_n)) |-> $stable(bus_addr)); // R8
endmodule

// File: tb/rmw_seq_test.sv
`timescale 1ns/1ps
module rmw_seq_test;
  localparam int AW = 32, DW = 16, FCW = 4, GAP_PH = 2, WCW = 8;
  localparam int MAXP = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [FCW-1:0] req_fc = '0;
  logic [1:0] req_siz = '0, req_op = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] sack_n = 2'b11;
  logic [DW-1:0] din;
  logic [AW-1:0] bus_addr;
  logic [FCW-1:0] bus_fc;
  logic [1:0] bus_siz;
  logic bus_rw, as_n, ds_n, lock_n, dben, done;
  logic [DW-1:0] dout, rdata;
  logic [WCW-1:0] wait_cnt;

  int errors = 0, checks = 0;
  int dly_r = 0, dly_w = 0, acnt = 0;
  logic [1:0] ack_pat = 2'b00;
  logic [DW-1:0] mem_val = '0;

  logic rec_as [MAXP], rec_ds [MAXP], rec_rw [MAXP], rec_lk [MAXP];
  logic rec_den [MAXP], rec_done [MAXP];
  logic [AW-1:0] rec_addr [MAXP];
  logic [DW-1:0] rec_dout [MAXP];
  int dn;

  always #2 clk = ~clk;

  rmw_seq uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .req_fc(req_fc), .req_siz(req_siz), .req_op(req_op),
    .req_wdata(req_wdata), .sack_n(sack_n), .din(din),
    .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_siz(bus_siz),
    .bus_rw(bus_rw), .as_n(as_n), .ds_n(ds_n), .lock_n(lock_n),
    .dben(dben), .dout(dout), .rdata(rdata), .done(done),
    .wait_cnt(wait_cnt));

  assign din = bus_rw ? mem_val : '0;

  // Slave model: acknowledge once the strobe has been low for more than D phases.
  always @(negedge clk) begin
    if (!as_n) acnt = acnt + 1; else acnt = 0;
    sack_n = (acnt > (bus_rw ? dly_r : dly_w)) ? ack_pat : 2'b11;
  end

  task automatic chk(input bit ok, input string rq, input longint act,
                     input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int waits_for(input int d);
    return (d + 2) / 2;
  endfunction

  function automatic logic [DW-1:0] expect_wr(input logic [1:0] op,
      input logic [DW-1:0] m, input logic [DW-1:0] w);
    if (op == 2'b01) return w;
    if (op == 2'b10) return m | w;
    return m ^ w;
  endfunction

  task automatic run_txn(input logic [AW-1:0] a, input logic [FCW-1:0] fc,
                         input logic [1:0] sz, input logic [1:0] op,
                         input logic [DW-1:0] m, input logic [DW-1:0] w,
                         input int dr, input int dw, input logic [1:0] pat);
    dly_r = dr; dly_w = dw; ack_pat = pat; mem_val = m; dn = -1;
    @(negedge clk);
    req = 1'b1; req_addr = a; req_fc = fc; req_siz = sz; req_op = op;
    req_wdata = w;
    for (int i = 0; i < MAXP; i++) begin
      @(negedge clk);
      req = 1'b0;
      rec_as[i] = as_n; rec_ds[i] = ds_n; rec_rw[i] = bus_rw;
      rec_lk[i] = lock_n; rec_den[i] = dben; rec_done[i] = done;
      rec_addr[i] = bus_addr; rec_dout[i] = dout;
      if (done) begin dn = i; break; end
    end
  endtask

  task automatic judge(input logic [AW-1:0] a, input logic [FCW-1:0] fc,
                       input logic [1:0] sz, input logic [1:0] op,
                       input logic [DW-1:0] m, input logic [DW-1:0] w,
                       input int dr, input int dw);
    int ar, w0, exp_w;
    bit held, den_rd, lk_ok;
    chk(dn > 0, "R9 done seen", dn, 1);
    if (dn <= 0) return;
    chk(rec_lk[0] == 0 && rec_rw[0] == 1 && rec_as[0] == 1 && rec_ds[0] == 1,
        "R1 first phase", {rec_lk[0], rec_rw[0], rec_as[0], rec_ds[0]}, 4'b0111);
    chk(rec_addr[0] == a && uut.bus_fc == fc && bus_siz == sz,
        "R1 address/fc/size", rec_addr[0], a);
    chk(rec_as[1] == 0 && rec_ds[1] == 0, "R2 read strobes together",
        {rec_as[1], rec_ds[1]}, 0);
    chk(rdata == m, "R4 read data", rdata, m);
    lk_ok = 1; held = 1;
    for (int i = 0; i < dn; i++) begin
      if (rec_lk[i]) lk_ok = 0;
      if (rec_addr[i] != a) held = 0;
    end
    chk(lk_ok && rec_lk[dn] == 1, "R9 lock window ends with done", lk_ok, 1);
    chk(held, "R8 address held under lock", held, 1);
    ar = -1;
    for (int i = 2; i < dn; i++) if (rec_as[i] && ar < 0) ar = i;
    exp_w = waits_for(dr) + ((op == 2'b00) ? 0 : waits_for(dw));
    chk(int'(wait_cnt) == exp_w, "R3 wait states", wait_cnt, exp_w);
    w0 = -1; den_rd = 0;
    for (int i = 0; i <= dn; i++) begin
      if (!rec_rw[i] && w0 < 0) w0 = i;
      if (rec_den[i] && rec_rw[i]) den_rd = 1;
    end
    chk(!den_rd, "R5 no drive while reading", den_rd, 0);
    if (op == 2'b00) begin
      chk(w0 < 0, "R10 no write phase", w0, -1);
      chk(dn == ar + 1, "R10 done after read release", dn, ar + 1);
    end else begin
      chk(w0 > 0 && rec_as[w0] && !rec_as[w0+1] && !rec_den[w0+1] && rec_den[w0+2],
          "R5 write entry order", {rec_as[w0], rec_as[w0+1], rec_den[w0+2]}, 3'b101);
      chk(rec_ds[w0+2] && !rec_ds[w0+3], "R6 write data strobe lag",
          {rec_ds[w0+2], rec_ds[w0+3]}, 2'b10);
      chk(rec_dout[w0+3] == expect_wr(op, m, w), "R7 written value",
          rec_dout[w0+3], expect_wr(op, m, w));
      chk(w0 - ar == GAP_PH + 1, "R8 gap length", w0 - ar, GAP_PH + 1);
    end
    @(negedge clk);
    chk(done == 0, "R9 done single phase", done, 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(as_n && ds_n && lock_n && bus_rw && !dben && !done, "R11 reset state",
        {as_n, ds_n, lock_n, bus_rw, dben, done}, 6'b111100);
  endtask

  task automatic test_store_fast();
    run_txn(32'h0000_1230, 4'h5, 2'b10, 2'b01, 16'hA5A5, 16'h1234, 0, 0, 2'b00);
    judge(32'h0000_1230, 4'h5, 2'b10, 2'b01, 16'hA5A5, 16'h1234, 0, 0);
  endtask

  task automatic test_set_slow_write();
    run_txn(32'hDEAD_0010, 4'h1, 2'b01, 2'b10, 16'h0F00, 16'h0081, 1, 5, 2'b01);
    judge(32'hDEAD_0010, 4'h1, 2'b01, 2'b10, 16'h0F00, 16'h0081, 1, 5);
  endtask

  task automatic test_flip_slow_read();
    run_txn(32'h8000_0002, 4'hD, 2'b00, 2'b11, 16'hFFFF, 16'h00F0, 4, 3, 2'b10);
    judge(32'h8000_0002, 4'hD, 2'b00, 2'b11, 16'hFFFF, 16'h00F0, 4, 3);
  endtask

  task automatic test_skip_write();
    run_txn(32'h0404_0404, 4'h2, 2'b11, 2'b00, 16'h5A5A, 16'hFFFF, 2, 0, 2'b00);
    judge(32'h0404_0404, 4'h2, 2'b11, 2'b00, 16'h5A5A, 16'hFFFF, 2, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_store_fast();
    test_set_slow_write();
    test_flip_slow_read();
    test_skip_write();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule